// File: doc/BRIEF.md
# Serial Flash Status and Power-Mode Controller

This block keeps the two status flags a host polls on a serial flash, the write-enable latch and the write-in-progress flag, and decides which power state the device is in. A command decoder ahead of it presents one strobe per decoded command while chip select is low, plus a level that says whether the frame was well formed. The internal write engine reports a busy level. The block answers with a status byte, an encoded power state, a command-block flag and a one-cycle grant that starts the write engine.

Commands act when chip select rises at the end of a well-formed frame. Deselection is not the same as standby. The device counts as active while it is selected and also while any internal write, program or erase cycle is still running. It drops to standby only when both have ended. A deep power-down command moves the device into a third, lower-power state. In that state every command but the release command is discarded. Reset returns the block to standby with both flags clear. While reset is held, no write can be granted.

Top module: `flash_pwr_status_ctl`

## Requirements
- R1: While rst_n is low and in the first cycle after it is released, status is 8'h00, pwr_state is 2'b00 (standby), cmd_block is 0 and wr_grant is 0, even if a well-formed program frame ends during reset.
- R2: status bit 0 is write-in-progress, bit 1 is the write-enable latch, and bits 7..2 always read 0.
- R3: From the second clock edge after cs_n falls, pwr_state reads 2'b01 (active) for as long as cs_n stays low, unless the device is in deep power-down.
- R4: After cs_n rises, pwr_state stays 2'b01 while write-in-progress is set and reads 2'b00 (standby) once it clears.
- R5: A write-enable frame ending with frame_ok high sets status bit 1, and a write-disable frame clears it. Both take effect on the second clock edge after cs_n rises. A frame that ends with frame_ok low changes nothing.
- R6: A well-formed program frame with the latch set and no cycle in progress gives a single-cycle wr_grant pulse and sets status bit 0 on the same edge. Without the latch set, no grant is given.
- R7: Write-in-progress stays set while eng_busy is high and clears on the first edge at which eng_busy is low after having been high. The write-enable latch clears on that same edge.
- R8: A well-formed deep power-down frame sets pwr_state to 2'b10 and cmd_block to 1, unless write-in-progress is set, in which case it is rejected.
- R9: In deep power-down, every command other than release is discarded: write-enable does not set the latch, program gives no grant, and pwr_state stays 2'b10 even while cs_n is low.
- R10: A well-formed release frame leaves deep power-down, returning pwr_state to 2'b00 and cmd_block to 0. A release frame that ends with frame_ok low is ignored.
- R11: While write-in-progress is set, write-enable, write-disable and program frames are ignored: the latch keeps its value and no grant is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, also blocks writes |
| cs_n | input | 1 | Chip select level, low while selected |
| frame_ok | input | 1 | Frame well formed, valid when cs_n rises |
| cmd_wren | input | 1 | Write-enable command strobe |
| cmd_wrdi | input | 1 | Write-disable command strobe |
| cmd_prog | input | 1 | Write, program or erase command strobe |
| cmd_dpd | input | 1 | Deep power-down command strobe |
| cmd_rel | input | 1 | Release from deep power-down strobe |
| cmd_misc | input | 1 | Any other command (reads, status poll) |
| eng_busy | input | 1 | Internal write engine busy |
| status | output | 8 | Status byte for polling |
| pwr_state | output | 2 | 00 standby, 01 active, 10 deep power-down |
| cmd_block | output | 1 | High while commands other than release are blocked |
| wr_grant | output | 1 | One-cycle start pulse for the write engine |

## Verification
If the pending command register or the latch holds a wrong value, the error shows on status or wr_grant on the second edge after cs_n rises. A host polling bit 0 or bit 1 sees it on the next read. A wrong write-in-progress value shows one edge after eng_busy changes, as a status bit 0 that disagrees with the engine and as pwr_state reading standby too early or active too long. A wrong deep power-down flag shows on pwr_state and cmd_block right after the frame that should have set or cleared it. Later write-enable frames then either take effect when they should have been discarded or are discarded when they should have taken effect.

// File: rtl/flash_pwr_pkg.sv
package flash_pwr_pkg;

   typedef enum logic [2:0] {
      CMD_NONE = 3'd0,
      CMD_WREN = 3'd1,
      CMD_WRDI = 3'd2,
      CMD_PROG = 3'd3,
      CMD_DPD  = 3'd4,
      CMD_REL  = 3'd5,
      CMD_MISC = 3'd6
   } cmd_e;

   typedef enum logic [1:0] {
      PWR_STBY = 2'b00,
      PWR_ACT  = 2'b01,
      PWR_DEEP = 2'b10
   } pwr_e;

endpackage

// File: rtl/flash_frame_trk.sv
module flash_frame_trk
   import flash_pwr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic frame_ok,
   input  cmd_e cmd_in,
   input  logic dpd_q,
   output logic cs_sel,
   output logic exec_valid,
   output cmd_e exec_cmd
);

   logic cs_q, cs_qq, fo_q, rise;
   cmd_e pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q   <= 1'b1;
         cs_qq  <= 1'b1;
         fo_q   <= 1'b0;
         pend_q <= CMD_NONE;
      end else begin
         cs_q  <= cs_n;
         cs_qq <= cs_q;
         fo_q  <= frame_ok;
         if (rise)
            pend_q <= CMD_NONE;
         else if (!cs_n && cmd_in != CMD_NONE && (!dpd_q || cmd_in == CMD_REL))
            pend_q <= cmd_in;
      end
   end

   assign rise       = cs_q & ~cs_qq;
   assign cs_sel     = ~cs_q;
   assign exec_valid = rise & fo_q & (pend_q != CMD_NONE);
   assign exec_cmd   = pend_q;

   // R9: once asleep, only a release may be waiting
   p_sleep_filter_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dpd_q && pend_q != CMD_NONE) |-> pend_q == CMD_REL);

   // R5: an executed command is consumed
   p_pending_consumed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      exec_valid |=> !exec_valid);

endmodule

// File: rtl/flash_wr_status.sv
module flash_wr_status
   import flash_pwr_pkg::*;
#(
   parameter bit WEL_CLR_AT_GRANT = 1'b0
)(
   input  logic clk,
   input  logic rst_n,
   input  logic exec_valid,
   input  cmd_e exec_cmd,
   input  logic eng_busy,
   input  logic dpd_q,
   output logic wip,
   output logic wel,
   output logic wr_grant
);

   logic wip_q, wel_q, seen_q, grant_q;
   logic grant, done, wel_set, wel_clr_cmd, wel_clr_evt;
   logic wip_n, wel_n, seen_n;

   assign wel_set     = exec_valid && exec_cmd == CMD_WREN && !wip_q && !dpd_q;
   assign wel_clr_cmd = exec_valid && exec_cmd == CMD_WRDI && !wip_q;
   assign grant       = exec_valid && exec_cmd == CMD_PROG && wel_q && !wip_q && !dpd_q;
   assign done        = wip_q && seen_q && !eng_busy;

   generate
      if (WEL_CLR_AT_GRANT) begin : g_clr_grant
         assign wel_clr_evt = grant;
      end else begin : g_clr_done
         assign wel_clr_evt = done;
      end
   endgenerate

   always_comb begin
      wip_n  = grant | eng_busy | (wip_q & ~done);
      seen_n = wip_n & (seen_q | eng_busy);
      wel_n  = wel_q;
      if (wel_clr_cmd || wel_clr_evt)
         wel_n = 1'b0;
      else if (wel_set)
         wel_n = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wip_q   <= 1'b0;
         wel_q   <= 1'b0;
         seen_q  <= 1'b0;
         grant_q <= 1'b0;
      end else begin
         wip_q   <= wip_n;
         wel_q   <= wel_n;
         seen_q  <= seen_n;
         grant_q <= grant;
      end
   end

   assign wip      = wip_q;
   assign wel      = wel_q;
   assign wr_grant = grant_q;

   p_grant_sets_wip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_grant |-> wip_q);

   p_grant_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_grant |=> !wr_grant);

   p_busy_holds_wip_r7: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy |=> wip_q);

   // R11: the latch does not move while a cycle runs, except on completion
   p_latch_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wip_q && !done && !WEL_CLR_AT_GRANT) |=> $stable(wel_q));

   generate
      if (!WEL_CLR_AT_GRANT) begin : g_chk_done
         p_wel_clear_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(wip_q) |-> !wel_q);
      end
   endgenerate

endmodule

// File: rtl/flash_pwr_mode.sv
module flash_pwr_mode
   import flash_pwr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic exec_valid,
   input  cmd_e exec_cmd,
   input  logic wip,
   input  logic cs_sel,
   output logic dpd_q,
   output pwr_e pwr_state
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dpd_q <= 1'b0;
      else if (exec_valid && exec_cmd == CMD_REL)
         dpd_q <= 1'b0;
      else if (exec_valid && exec_cmd == CMD_DPD && !wip)
         dpd_q <= 1'b1;
   end

   always_comb begin
      if (dpd_q)
         pwr_state = PWR_DEEP;
      else if (cs_sel || wip)
         pwr_state = PWR_ACT;
      else
         pwr_state = PWR_STBY;
   end

   p_sel_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cs_sel |-> pwr_state != PWR_STBY);

   p_wip_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wip |-> pwr_state != PWR_STBY);

   p_sleep_needs_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dpd_q) |-> $past(!wip));

endmodule

// File: rtl/flash_pwr_status_ctl.sv
module flash_pwr_status_ctl
   import flash_pwr_pkg::*;
#(
   parameter int STATUS_W         = 8,
   parameter int WIP_POS          = 0,
   parameter int WEL_POS          = 1,
   parameter bit WEL_CLR_AT_GRANT = 1'b0
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n,
   input  logic                frame_ok,
   input  logic                cmd_wren,
   input  logic                cmd_wrdi,
   input  logic                cmd_prog,
   input  logic                cmd_dpd,
   input  logic                cmd_rel,
   input  logic                cmd_misc,
   input  logic                eng_busy,
   output logic [STATUS_W-1:0] status,
   output logic [1:0]          pwr_state,
   output logic                cmd_block,
   output logic                wr_grant
);

   localparam int FLAG_CNT = 2;

   generate
      if (STATUS_W < FLAG_CNT) begin : g_bad_width
         $error("STATUS_W too small for the status flags");
      end
      if (WIP_POS == WEL_POS || WIP_POS >= STATUS_W || WEL_POS >= STATUS_W
          || WIP_POS < 0 || WEL_POS < 0) begin : g_bad_pos
         $error("status flag positions invalid");
      end
   endgenerate

   cmd_e cmd_in, exec_cmd;
   logic exec_valid, cs_sel, dpd_q, wip, wel;
   pwr_e pwr_e_s;

   always_comb begin
      if (cmd_rel)       cmd_in = CMD_REL;
      else if (cmd_dpd)  cmd_in = CMD_DPD;
      else if (cmd_wrdi) cmd_in = CMD_WRDI;
      else if (cmd_wren) cmd_in = CMD_WREN;
      else if (cmd_prog) cmd_in = CMD_PROG;
      else if (cmd_misc) cmd_in = CMD_MISC;
      else               cmd_in = CMD_NONE;
   end

   flash_frame_trk u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n       (cs_n),
      .frame_ok   (frame_ok),
      .cmd_in     (cmd_in),
      .dpd_q      (dpd_q),
      .cs_sel     (cs_sel),
      .exec_valid (exec_valid),
      .exec_cmd   (exec_cmd)
   );

   flash_wr_status #(.WEL_CLR_AT_GRANT(WEL_CLR_AT_GRANT)) u_wr (
      .clk        (clk),
      .rst_n      (rst_n),
      .exec_valid (exec_valid),
      .exec_cmd   (exec_cmd),
      .eng_busy   (eng_busy),
      .dpd_q      (dpd_q),
      .wip        (wip),
      .wel        (wel),
      .wr_grant   (wr_grant)
   );

   flash_pwr_mode u_pwr (
      .clk        (clk),
      .rst_n      (rst_n),
      .exec_valid (exec_valid),
      .exec_cmd   (exec_cmd),
      .wip        (wip),
      .cs_sel     (cs_sel),
      .dpd_q      (dpd_q),
      .pwr_state  (pwr_e_s)
   );

   always_comb begin
      status          = '0;
      status[WIP_POS] = wip;
      status[WEL_POS] = wel;
   end

   assign pwr_state = pwr_e_s;
   assign cmd_block = dpd_q;

   p_block_means_deep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_block |-> pwr_state == PWR_DEEP);

   p_spare_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(status) <= FLAG_CNT);

endmodule

// File: tb/test_flash_pwr_status_ctl.sv
module test_flash_pwr_status_ctl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, frame_ok = 1'b0;
   logic       cmd_wren = 0, cmd_wrdi = 0, cmd_prog = 0, cmd_dpd = 0, cmd_rel = 0, cmd_misc = 0;
   logic       eng_busy = 1'b0;
   logic [7:0] status;
   logic [1:0] pwr_state;
   logic       cmd_block, wr_grant;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   localparam int C_WREN = 0, C_WRDI = 1, C_PROG = 2, C_DPD = 3, C_REL = 4, C_MISC = 5;

   always #2 clk = ~clk;

   flash_pwr_status_ctl i_flash_pwr_status_ctl (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .frame_ok(frame_ok),
      .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_prog(cmd_prog),
      .cmd_dpd(cmd_dpd), .cmd_rel(cmd_rel), .cmd_misc(cmd_misc),
      .eng_busy(eng_busy), .status(status), .pwr_state(pwr_state),
      .cmd_block(cmd_block), .wr_grant(wr_grant)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // framed command; returns at the negedge after the executing edge
   task automatic send(input int which, input bit ok);
      @(negedge clk) cs_n = 1'b0;
      @(negedge clk);
      case (which)
         C_WREN: cmd_wren = 1'b1;
         C_WRDI: cmd_wrdi = 1'b1;
         C_PROG: cmd_prog = 1'b1;
         C_DPD:  cmd_dpd  = 1'b1;
         C_REL:  cmd_rel  = 1'b1;
         default: cmd_misc = 1'b1;
      endcase
      @(negedge clk);
      {cmd_wren, cmd_wrdi, cmd_prog, cmd_dpd, cmd_rel, cmd_misc} = '0;
      @(negedge clk);
      cs_n = 1'b1;
      frame_ok = ok;
      @(negedge clk);
      @(negedge clk);
      frame_ok = 1'b0;
   endtask

   task automatic t_reset;
      // R1: a program frame ends while reset is held
      send(C_PROG, 1'b1);
      chk("R1 grant in reset", {31'd0, wr_grant}, 32'd0);
      chk("R1 status in reset", {24'd0, status}, 32'h00);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      chk("R1 status", {24'd0, status}, 32'h00);
      chk("R1 pwr", {30'd0, pwr_state}, 32'd0);
      chk("R1 block", {31'd0, cmd_block}, 32'd0);
   endtask

   task automatic t_active;
      @(negedge clk) cs_n = 1'b0;
      @(negedge clk);
      chk("R3 selected active", {30'd0, pwr_state}, 32'd1);
      cmd_misc = 1'b1;
      @(negedge clk) cmd_misc = 1'b0;
      @(negedge clk) cs_n = 1'b1; frame_ok = 1'b1;
      @(negedge clk) frame_ok = 1'b0;
      chk("R4 idle standby", {30'd0, pwr_state}, 32'd0);
      chk("R2 misc no effect", {24'd0, status}, 32'h00);
   endtask

   task automatic t_latch;
      send(C_WREN, 1'b0);
      chk("R5 unframed wren", {24'd0, status}, 32'h00);
      send(C_WREN, 1'b1);
      chk("R5 wren sets bit1", {24'd0, status}, 32'h02);
      send(C_WRDI, 1'b1);
      chk("R5 wrdi clears", {24'd0, status}, 32'h00);
      send(C_PROG, 1'b1);
      chk("R6 no latch no grant", {31'd0, wr_grant}, 32'd0);
      chk("R6 no latch status", {24'd0, status}, 32'h00);
   endtask

   task automatic t_program;
      send(C_WREN, 1'b1);
      send(C_PROG, 1'b1);
      chk("R6 grant", {31'd0, wr_grant}, 32'd1);
      chk("R2 wip and wel", {24'd0, status}, 32'h03);
      @(negedge clk);
      chk("R6 grant pulse ends", {31'd0, wr_grant}, 32'd0);
      chk("R4 busy keeps active", {30'd0, pwr_state}, 32'd1);
      eng_busy = 1'b1;
      send(C_WRDI, 1'b1);
      chk("R11 wrdi ignored", {24'd0, status}, 32'h03);
      send(C_PROG, 1'b1);
      chk("R11 prog no grant", {31'd0, wr_grant}, 32'd0);
      send(C_DPD, 1'b1);
      chk("R8 dpd rejected busy", {30'd0, pwr_state}, 32'd1);
      chk("R8 block stays low", {31'd0, cmd_block}, 32'd0);
      chk("R7 wip while busy", {24'd0, status}, 32'h03);
      @(negedge clk) eng_busy = 1'b0;
      @(negedge clk);
      chk("R7 done clears both", {24'd0, status}, 32'h00);
      chk("R4 standby after cycle", {30'd0, pwr_state}, 32'd0);
   endtask

   task automatic t_sleep;
      send(C_DPD, 1'b1);
      chk("R8 deep", {30'd0, pwr_state}, 32'd2);
      chk("R8 block", {31'd0, cmd_block}, 32'd1);
      send(C_WREN, 1'b1);
      chk("R9 wren discarded", {24'd0, status}, 32'h00);
      send(C_PROG, 1'b1);
      chk("R9 prog discarded", {31'd0, wr_grant}, 32'd0);
      @(negedge clk) cs_n = 1'b0;
      @(negedge clk);
      chk("R9 selected still deep", {30'd0, pwr_state}, 32'd2);
      @(negedge clk) cs_n = 1'b1;
      send(C_REL, 1'b0);
      chk("R10 unframed release", {30'd0, pwr_state}, 32'd2);
      send(C_REL, 1'b1);
      chk("R10 released", {30'd0, pwr_state}, 32'd0);
      chk("R10 unblocked", {31'd0, cmd_block}, 32'd0);
      chk("R9 no latch after wake", {24'd0, status}, 32'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_active();
      t_latch();
      t_program();
      t_sleep();
      repeat (2) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_bad++;
         $display("FAIL R1 watchdog: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule